// File: doc/BRIEF.md
# Multi-Source Fractional Clock Divider

This block is a per-peripheral rate generator that works on single-cycle strobes rather than on real clocks. Ten strobe inputs are presented to it. A control word chooses one of them and gates the path with an enable bit. A divide word scales the chosen rate by 2^F / D, where D is a fixed-point divisor with I integer bits and F fraction bits. The result is one output strobe stream, together with a busy status that follows the enable bit.

Input slot 0 is always dead. By convention slot 1 carries the main oscillator and slots 2 and 3 carry the two debug clocks; the remaining slots are assigned per instance. An elaboration mask can tie any slot to ground. The fractional rate comes from an accumulator: every accepted source strobe adds 2^F, and each time the total reaches D an output strobe is produced and D is taken off. An instance built with I = F = 0 has no divider and forwards the chosen strobe unchanged.

The surrounding register bus loads the two words through plain write strobes. Any write to either word restarts the accumulation from zero.

Top module: `frac_clk_gen`

## Requirements
- R1: Bits [3:0] of the control word choose the source slot from 0 to 9. Only strobes on the chosen slot affect the output. Values 10 to 15 choose nothing and produce no output.
- R2: Slot 0, and every slot whose bit is set in the GND_MASK parameter, never produces an output strobe.
- R3: Bit 4 of the control word is the enable bit. While it is clear, no output strobe is produced.
- R4: The control read-back holds the source in [3:0], the enable in [4] and zero in [6:5]. Its busy bit [7] and the busy_o output equal the enable, starting in the cycle after the write.
- R5: The divisor D is bits [12+I-1 : 12-F] of the divide word. All other bits of that word have no effect.
- R6: When D > 2^F, the n-th accepted source strobe after a clear produces an output strobe exactly when floor(n·2^F/D) > floor((n-1)·2^F/D). That output is high in the cycle after the source strobe is sampled.
- R7: When 0 < D ≤ 2^F, every accepted source strobe produces an output strobe one cycle later.
- R8: When D = 0, the output is stopped.
- R9: An instance with I = F = 0 passes the chosen, enabled strobe to the output with one cycle of delay and ignores the divide word.
- R10: A write to the control word or to the divide word clears the accumulator, so the count n in R6 restarts from 1.
- R11: After reset the output is low, busy is low, the control read-back is zero and D is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_stb | input | 10 | One-cycle strobes from the ten source slots |
| ctrl_we | input | 1 | Load the control word |
| ctrl_wdata | input | 8 | Control word: source [3:0], enable [4]; bits [7:5] are ignored |
| div_we | input | 1 | Load the divide word |
| div_wdata | input | 32 | Divide word; the divisor sits with its integer part at bit 12 |
| stb_o | output | 1 | Divided output strobe |
| busy_o | output | 1 | Busy status, equal to the enable bit |
| ctrl_rd_o | output | 8 | Control read-back with busy in bit 7 |

## Verification
The hardest behaviour to reach is the accumulator clear on a rewrite. A write that lands mid-count must discard a partial sum that would otherwise have fired on the very next strobe. To reach it, the stimulus first fills the accumulator to within one step of D. It then rewrites the same divisor, or the same control value, and shows that one further strobe stays silent while the third strobe fires. Source isolation is covered by toggling every unselected slot every cycle and pulsing the chosen slot only every third cycle. A second instance without divider bits receives the same stimulus, which confirms the pass-through variant.

// File: rtl/fcg_pkg.sv
package fcg_pkg;
    localparam int NUM_SRC       = 10;
    localparam int SEL_W         = 4;
    localparam int CTRL_W        = 8;
    localparam int DIV_W         = 32;
    localparam int INT_LSB       = 12;
    localparam int CTRL_EN_BIT   = 4;
    localparam int CTRL_BUSY_BIT = 7;
endpackage

// File: rtl/fcg_src_pick.sv
module fcg_src_pick
    import fcg_pkg::*;
#(
    parameter logic [NUM_SRC-1:0] GND_MASK = '0
) (
    input  logic [NUM_SRC-1:0] src_stb,
    input  logic [SEL_W-1:0]   sel,
    output logic               stb
);
    localparam int EXT = 1 << SEL_W;

    logic [NUM_SRC-1:0] live;
    logic [EXT-1:0]     live_ext;

    // slot 0 is always ground; others may be forced to ground by the mask
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        if (i == 0) begin : g_gnd
            assign live[i] = 1'b0;
        end else begin : g_live
            assign live[i] = src_stb[i] & ~GND_MASK[i];
        end
    end

    wire unused_slot0 = src_stb[0];

    always_comb begin
        live_ext = EXT'(live);
        stb      = live_ext[sel];
    end
endmodule

// File: rtl/fcg_accum.sv
module fcg_accum #(
    parameter int INT_W  = 4,
    parameter int FRAC_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    stb_in,
    input  logic [INT_W+FRAC_W-1:0] div,
    output logic                    stb_out
);
    localparam int DW   = INT_W + FRAC_W;
    localparam int AW   = DW + 1;
    localparam int STEP = 1 << FRAC_W;

    typedef struct packed {
        logic [AW-1:0] acc;
        logic          out;
    } acc_t;

    acc_t st_d, st_q;
    logic [AW-1:0] sum, div_x;

    always_comb begin
        st_d     = st_q;
        st_d.out = 1'b0;
        div_x    = AW'(div);
        sum      = st_q.acc + AW'(STEP);
        if (clr) begin
            st_d.acc = '0;
        end else if (stb_in && div != '0) begin
            if (div_x <= AW'(STEP)) begin
                st_d.out = 1'b1;
                st_d.acc = '0;
            end else if (sum >= div_x) begin
                st_d.out = 1'b1;
                st_d.acc = sum - div_x;
            end else begin
                st_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stb_out = st_q.out;

    assert_acc_below_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div != '0) |-> (st_q.acc < AW'(div)));
    assert_zero_div_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0) |=> !stb_out);
    assert_out_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stb_out |-> $past(stb_in));
endmodule

// File: rtl/frac_clk_gen.sv
module frac_clk_gen
    import fcg_pkg::*;
#(
    parameter int                 INT_W    = 4,
    parameter int                 FRAC_W   = 4,
    parameter logic [NUM_SRC-1:0] GND_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_stb,
    input  logic               ctrl_we,
    input  logic [CTRL_W-1:0]  ctrl_wdata,
    input  logic               div_we,
    input  logic [DIV_W-1:0]   div_wdata,
    output logic               stb_o,
    output logic               busy_o,
    output logic [CTRL_W-1:0]  ctrl_rd_o
);
    localparam int DW  = INT_W + FRAC_W;
    localparam int DWQ = (DW > 0) ? DW : 1;
    localparam int LO  = INT_LSB - FRAC_W;

    typedef struct packed {
        logic [SEL_W-1:0] src;
        logic             en;
        logic [DWQ-1:0]   div;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [DWQ-1:0] div_ext;
    logic sel_stb, gated, clr;

    if (DW > 0) begin : g_ext
        assign div_ext = div_wdata[LO +: DWQ];
    end else begin : g_noext
        assign div_ext = 1'b0;
    end

    always_comb begin
        cfg_d = cfg_q;
        if (ctrl_we) begin
            cfg_d.src = ctrl_wdata[SEL_W-1:0];
            cfg_d.en  = ctrl_wdata[CTRL_EN_BIT];
        end
        if (div_we) cfg_d.div = div_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    fcg_src_pick #(.GND_MASK(GND_MASK)) u_pick (
        .src_stb (src_stb),
        .sel     (cfg_q.src),
        .stb     (sel_stb)
    );

    assign clr   = ctrl_we | div_we;
    assign gated = sel_stb & cfg_q.en & ~clr;

    if (DW == 0) begin : g_bypass
        logic byp_d, byp_q;
        always_comb byp_d = gated;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) byp_q <= 1'b0;
            else        byp_q <= byp_d;
        end
        assign stb_o = byp_q;
    end else begin : g_frac
        fcg_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .stb_in  (gated),
            .div     (cfg_q.div[DWQ-1:0]),
            .stb_out (stb_o)
        );
    end

    wire unused_bits = ^{div_wdata, ctrl_wdata[CTRL_W-1:CTRL_EN_BIT+1], cfg_q.div};

    assign busy_o    = cfg_q.en;
    assign ctrl_rd_o = {cfg_q.en, {(CTRL_W-SEL_W-2){1'b0}}, cfg_q.en, cfg_q.src};

    assert_busy_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_we) |-> (busy_o == $past(ctrl_wdata[CTRL_EN_BIT])));
    assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> !stb_o);
    assert_ground_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd_o[SEL_W-1:0] == '0) |=> !stb_o);
endmodule

// File: tb/tb_frac_clk_gen.sv
module tb_frac_clk_gen;
    localparam logic [9:0] MASK = 10'b10_0000_0000;
    localparam int STEP = 16;

    logic clk = 0, rst_n = 0;
    logic [9:0] src_stb = '0;
    logic ctrl_we = 0, div_we = 0;
    logic [7:0] ctrl_wdata = '0;
    logic [31:0] div_wdata = '0;
    logic stb_o, busy_o, stb_b, busy_b;
    logic [7:0] ctrl_rd_o, ctrl_rd_b;

    int cyc = 0, errors = 0, checks = 0;
    int q_frac[$], q_byp[$];
    string cur_req = "R11";
    int m_src = 0, m_en = 0, m_div = 0, m_n = 0;
    bit mon_on = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frac_clk_gen #(.INT_W(4), .FRAC_W(4), .GND_MASK(MASK)) dut (
        .clk(clk), .rst_n(rst_n), .src_stb(src_stb), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .div_we(div_we), .div_wdata(div_wdata),
        .stb_o(stb_o), .busy_o(busy_o), .ctrl_rd_o(ctrl_rd_o));

    frac_clk_gen #(.INT_W(0), .FRAC_W(0), .GND_MASK(MASK)) dut_byp (
        .clk(clk), .rst_n(rst_n), .src_stb(src_stb), .ctrl_we(ctrl_we),
        .ctrl_wdata(ctrl_wdata), .div_we(div_we), .div_wdata(div_wdata),
        .stb_o(stb_b), .busy_o(busy_b), .ctrl_rd_o(ctrl_rd_b));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    function automatic bit fires(input int n, input int d);
        if (d == 0) return 0;
        if (d <= STEP) return 1;
        return ((n * STEP) / d) != (((n - 1) * STEP) / d);
    endfunction

    task automatic wr_ctrl(input int s, input int e);
        @(posedge clk); #2;
        src_stb = '0; ctrl_we = 1; ctrl_wdata = 8'((e << 4) | s | 8'hE0);
        m_src = s; m_en = e; m_n = 0;
        @(posedge clk); #2;
        ctrl_we = 0;
    endtask

    task automatic wr_div(input logic [31:0] w);
        @(posedge clk); #2;
        src_stb = '0; div_we = 1; div_wdata = w;
        m_div = int'((w >> 8) & 32'hFF); m_n = 0;
        @(posedge clk); #2;
        div_we = 0;
    endtask

    // one cycle of source strobes; pushes expected output cycles
    task automatic pulse(input logic [9:0] pat);
        bit act;
        @(posedge clk); #2;
        src_stb = pat;
        act = (m_en != 0) && (m_src > 0) && (m_src < 10) && !MASK[m_src] && pat[m_src];
        if (act) begin
            m_n++;
            q_byp.push_back(cyc + 1);
            if (fires(m_n, m_div)) q_frac.push_back(cyc + 1);
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk); #2;
            src_stb = '0;
        end
    endtask

    task automatic drained(input string req);
        idle(3);
        check(q_frac.size() == 0, req, q_frac.size(), 0);
        check(q_byp.size() == 0, "R9", q_byp.size(), 0);
    endtask

    // scoreboard monitor
    always @(negedge clk) if (mon_on) begin
        bit ef, eb;
        ef = (q_frac.size() > 0) && (q_frac[0] == cyc);
        if (ef) void'(q_frac.pop_front());
        if (ef || stb_o) check(stb_o == ef, cur_req, int'(stb_o), int'(ef));
        eb = (q_byp.size() > 0) && (q_byp[0] == cyc);
        if (eb) void'(q_byp.pop_front());
        if (eb || stb_b) check(stb_b == eb, "R9", int'(stb_b), int'(eb));
    end

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R11 reset state
        check(stb_o == 0, "R11", int'(stb_o), 0);
        check(busy_o == 0, "R11", int'(busy_o), 0);
        check(ctrl_rd_o == 0, "R11", int'(ctrl_rd_o), 0);
        mon_on = 1;

        // R8: enabled, reset divisor zero -> silent; R4 read-back
        cur_req = "R8";
        wr_ctrl(1, 1);
        @(negedge clk);
        check(busy_o == 1, "R4", int'(busy_o), 1);
        check(ctrl_rd_o == 8'h91, "R4", int'(ctrl_rd_o), 8'h91);
        for (int i = 0; i < 6; i++) pulse(10'h3FF);
        drained("R8");

        // R6 + R5: D=40 with junk outside the field
        cur_req = "R6_R5";
        wr_div(32'hFFFF_28FF);
        for (int i = 0; i < 30; i++) pulse(10'h3FF);
        drained("R6");

        // R1: slot 4 only every third cycle, all others always
        cur_req = "R1";
        wr_ctrl(4, 1);
        wr_div(32'd50 << 8);
        for (int i = 0; i < 45; i++) pulse((i % 3 == 0) ? 10'h3FF : 10'h3EF);
        drained("R1");

        // R7: D below and equal to 2^F, gapped
        cur_req = "R7";
        wr_div(32'd10 << 8);
        for (int i = 0; i < 12; i++) pulse((i % 2 == 0) ? 10'h010 : 10'h000);
        wr_div(32'd16 << 8);
        for (int i = 0; i < 6; i++) pulse(10'h010);
        drained("R7");

        // R1 out-of-range select, R2 slot 0 and masked slot 9
        cur_req = "R1";
        wr_ctrl(12, 1);
        for (int i = 0; i < 6; i++) pulse(10'h3FF);
        cur_req = "R2";
        wr_ctrl(0, 1);
        for (int i = 0; i < 6; i++) pulse(10'h3FF);
        wr_ctrl(9, 1);
        for (int i = 0; i < 6; i++) pulse(10'h3FF);
        drained("R2");

        // R3: disabled
        cur_req = "R3";
        wr_ctrl(1, 0);
        @(negedge clk);
        check(busy_o == 0, "R4", int'(busy_o), 0);
        check(ctrl_rd_o == 8'h01, "R4", int'(ctrl_rd_o), 8'h01);
        for (int i = 0; i < 8; i++) pulse(10'h3FF);
        drained("R3");

        // R10: rewrites clear a nearly full accumulator (D=48)
        cur_req = "R10";
        wr_ctrl(1, 1);
        wr_div(32'd48 << 8);
        pulse(10'h002); pulse(10'h002);
        wr_div(32'd48 << 8);
        for (int i = 0; i < 3; i++) pulse(10'h002);
        pulse(10'h002); pulse(10'h002);
        wr_ctrl(1, 1);
        for (int i = 0; i < 3; i++) pulse(10'h002);
        drained("R10");

        mon_on = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule